// File: doc/BRIEF.md
# Supervised Mode Controller with Fail-Safe Watchdog

This block decides the operating mode of a system basis chip that supervises a host microcontroller. The modes are Start-up, Normal, Standby, Sleep, Flash and Fail-safe. Each write strobe from the host carries a requested mode code and a new watchdog period. Every such write serves the watchdog. A mode change exists only as part of a write that is a valid service. When a service is late or out of window, the block asks for a system reset and returns to Start-up. It also latches a code that records why the reset happened.

Watchdog time is counted in ticks. A prescaler produces the ticks, dividing the clock by a base divisor times 1, 4, 16 or 64. The host's configuration write selects that factor. The same write holds a development bit that stops watchdog failures from resetting the system.

In Normal mode the watchdog is a window watchdog. In Standby, Sleep and Flash it is a plain time-out. In Start-up a fixed supervision limit applies, and the block tolerates one miss before it locks into Fail-safe.

Flash mode is reached in two steps. First the host writes a four-command sequence while in Normal. That sequence resets the chip. Then, from Start-up, the host sends a one-time acknowledge code.

States and transitions:
- Start-up goes to Normal when the Normal code is written.
- Start-up goes to Flash when the acknowledge code is written and flash entry is armed.
- Start-up restarts itself with a reset pulse on the first supervision miss.
- Start-up goes to Fail-safe on a second consecutive supervision miss.
- Normal goes to Standby or to Sleep on a write in the open window.
- Normal goes to Start-up on an early write, on a missed window, or when the flash sequence completes.
- Standby and Sleep can switch to each other, or go to Normal, on any write.
- Standby and Sleep go to Start-up on a time-out.
- Flash goes to Normal when the Normal code is written, and to Start-up on a time-out.
- Fail-safe is left only through the power-on reset.

Top module: `sbc_mode_supervisor`

## Requirements
- R1: While `rst_n` is low and after it rises, `mode` reads 0 (Start-up), `reset_src` reads 4'h1 and `reset_req` is 0.
- R2: Every write served in any mode other than Fail-safe restarts the watchdog. An early write in Normal applies no requested mode.
- R3: In Normal, with limit L ticks, a write while fewer than L/2 ticks have elapsed is a failure with `reset_src` 4'h3. A write with no failure sooner than L ticks after the last restart leads to a failure with `reset_src` 4'h4. A write in between is accepted.
- R4: In Standby, Sleep and Flash, any write restarts the watchdog. If no write arrives for L ticks, the result is a failure with `reset_src` 4'h5.
- R5: One tick is BASE_DIV·4^`cfg_prescale` clocks. L is `cmd_period`+1 ticks, taken from the last write. In Start-up, L is STARTUP_TICKS.
- R6: The first supervision miss in Start-up pulses `reset_req`, sets `reset_src` to 4'h2 and stays in Start-up. A second consecutive miss enters Fail-safe (`mode` 5) with no pulse.
- R7: In Fail-safe, writes are ignored and no `reset_req` occurs. Only `rst_n` leaves this mode.
- R8: In Normal, accepted writes of codes 3'b101, 3'b001, 3'b101, 3'b001 in that order cause a reset with `reset_src` 4'h6 and a return to Start-up.
- R9: In Start-up, code 3'b011 enters Flash (`mode` 4) only once after the R8 sequence. In any other case it leaves the mode unchanged.
- R10: With `cfg_devmode` set, a watchdog failure restarts the watchdog without a reset pulse and without a change of mode.
- R11: `reset_req` lasts one cycle. It rises on the same edge where `mode` becomes 0 and `reset_src` updates. `reset_src` then holds until the next reset event.
- R12: These codes act in these modes. 3'b101 gives Normal (`mode` 1). 3'b110 gives Standby (2). 3'b010 gives Sleep (3). The last two are not accepted from Start-up or Flash. Any other code keeps the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cmd_wr | input | 1 | Mode/service write strobe |
| cmd_mode | input | 3 | Requested mode code |
| cmd_period | input | PERIOD_W | Watchdog period field |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_prescale | input | 2 | Tick prescale select |
| cfg_devmode | input | 1 | Development bypass bit |
| mode | output | 3 | Current mode (0 Start-up, 1 Normal, 2 Standby, 3 Sleep, 4 Flash, 5 Fail-safe) |
| reset_req | output | 1 | One-cycle system reset request |
| reset_src | output | 4 | Cause of the last reset |

## Verification
Writes are placed at exact tick offsets after each watchdog restart. One offset falls inside the closed half of a Normal window and one falls inside the open half. Other runs send no write at all, so that early, late and accepted services can be told apart to the cycle.

Silent runs in Start-up show the retry and then the lock into Fail-safe. The same timing with a larger prescale shows that the period scales with the prescale setting.

The flash sequence is sent in full, and the acknowledge code is sent both while armed and after the arm has been used. Together these show that the acknowledge is accepted exactly once. Repeating the early and late cases with the development bit set shows that no reset is requested.

// File: rtl/sbcsup_pkg.sv
package sbcsup_pkg;

    typedef enum logic [2:0] {
        ST_STARTUP  = 3'd0,
        ST_NORMAL   = 3'd1,
        ST_STANDBY  = 3'd2,
        ST_SLEEP    = 3'd3,
        ST_FLASH    = 3'd4,
        ST_FAILSAFE = 3'd5
    } sbc_mode_e;

    // requested-mode codes carried by a service write
    localparam logic [2:0] CMD_NORMAL    = 3'b101;
    localparam logic [2:0] CMD_STANDBY   = 3'b110;
    localparam logic [2:0] CMD_SLEEP     = 3'b010;
    localparam logic [2:0] CMD_FLASH_SEQ = 3'b001;
    localparam logic [2:0] CMD_FLASH_ACK = 3'b011;

    // reset cause codes
    localparam logic [3:0] RSRC_POWERON      = 4'h1;
    localparam logic [3:0] RSRC_STARTUP_MISS = 4'h2;
    localparam logic [3:0] RSRC_WIN_EARLY    = 4'h3;
    localparam logic [3:0] RSRC_WIN_LATE     = 4'h4;
    localparam logic [3:0] RSRC_TIMEOUT      = 4'h5;
    localparam logic [3:0] RSRC_FLASH_ENTRY  = 4'h6;

endpackage

// File: rtl/sbcsup_tick_gen.sv
module sbcsup_tick_gen #(
    parameter int BASE_DIV = 4,
    localparam int DIV_MAX = BASE_DIV * 64,
    localparam int DW      = $clog2(DIV_MAX) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic [1:0] pre_i,
    output logic       tick_o
);

    logic [DW-1:0] div_cnt;
    logic [DW-1:0] div_last;

    // divide factor grows by four per prescale step
    always_comb begin
        case (pre_i)
            2'd0:    div_last = DW'(BASE_DIV - 1);
            2'd1:    div_last = DW'(BASE_DIV * 4 - 1);
            2'd2:    div_last = DW'(BASE_DIV * 16 - 1);
            default: div_last = DW'(BASE_DIV * 64 - 1);
        endcase
    end

    assign tick_o = (div_cnt >= div_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (clr_i || tick_o) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + DW'(1);
        end
    end

    // R5: the divider never runs past the largest divide factor
    a_r5_div_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt <= DW'(DIV_MAX - 1));

endmodule

// File: rtl/sbcsup_wdog.sv
module sbcsup_wdog #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic          expire_o,
    output logic          early_o
);

    logic [CW-1:0] cnt;

    assign expire_o = tick_i && (cnt == limit_i - CW'(1));
    assign early_o  = (cnt < (limit_i >> 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr_i) begin
            cnt <= '0;
        end else if (tick_i) begin
            cnt <= cnt + CW'(1);
        end
    end

    // R2/R4: every expiry is answered by a restart, so the count stays under the limit
    a_r4_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < limit_i);

endmodule

// File: rtl/sbcsup_mode_fsm.sv
module sbcsup_mode_fsm
    import sbcsup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr_i,
    input  logic [2:0] cmd_mode_i,
    input  logic       dev_i,
    input  logic       wd_expire_i,
    input  logic       wd_early_i,
    output sbc_mode_e  mode_o,
    output logic       rst_req_o,
    output logic [3:0] rst_src_o,
    output logic       wd_clr_o
);

    sbc_mode_e  st, nxt_st;
    logic       retry, nxt_retry;
    logic [1:0] step, nxt_step;
    logic       armed, nxt_armed;
    logic [3:0] nxt_src;
    logic       nxt_req;
    logic       fail;
    logic [3:0] fail_src;
    logic [2:0] seq_want;

    assign seq_want = step[0] ? CMD_FLASH_SEQ : CMD_NORMAL;

    always_comb begin
        nxt_st    = st;
        nxt_retry = retry;
        nxt_step  = step;
        nxt_armed = armed;
        nxt_src   = rst_src_o;
        nxt_req   = 1'b0;
        wd_clr_o  = 1'b0;
        fail      = 1'b0;
        fail_src  = rst_src_o;
        unique case (st)
            ST_STARTUP: begin
                if (cmd_wr_i) begin
                    wd_clr_o = 1'b1;
                    if (cmd_mode_i == CMD_NORMAL) begin
                        nxt_st    = ST_NORMAL;
                        nxt_retry = 1'b0;
                        nxt_armed = 1'b0;
                    end else if (cmd_mode_i == CMD_FLASH_ACK && armed) begin
                        nxt_st    = ST_FLASH;
                        nxt_retry = 1'b0;
                        nxt_armed = 1'b0;
                    end
                end else if (wd_expire_i) begin
                    wd_clr_o = 1'b1;
                    if (!dev_i) begin
                        if (retry) begin
                            nxt_st = ST_FAILSAFE;
                        end else begin
                            nxt_retry = 1'b1;
                            nxt_req   = 1'b1;
                            nxt_src   = RSRC_STARTUP_MISS;
                            nxt_armed = 1'b0;
                        end
                    end
                end
            end
            ST_NORMAL: begin
                if (cmd_wr_i) begin
                    wd_clr_o = 1'b1;
                    if (wd_early_i) begin
                        fail     = 1'b1;
                        fail_src = RSRC_WIN_EARLY;
                    end else if (cmd_mode_i == CMD_STANDBY) begin
                        nxt_st   = ST_STANDBY;
                        nxt_step = 2'd0;
                    end else if (cmd_mode_i == CMD_SLEEP) begin
                        nxt_st   = ST_SLEEP;
                        nxt_step = 2'd0;
                    end else if (cmd_mode_i == seq_want) begin
                        if (step == 2'd3) begin
                            nxt_st    = ST_STARTUP;
                            nxt_req   = 1'b1;
                            nxt_src   = RSRC_FLASH_ENTRY;
                            nxt_armed = 1'b1;
                            nxt_retry = 1'b0;
                            nxt_step  = 2'd0;
                        end else begin
                            nxt_step = step + 2'd1;
                        end
                    end else begin
                        nxt_step = (cmd_mode_i == CMD_NORMAL) ? 2'd1 : 2'd0;
                    end
                end else if (wd_expire_i) begin
                    wd_clr_o = 1'b1;
                    fail     = 1'b1;
                    fail_src = RSRC_WIN_LATE;
                end
            end
            ST_STANDBY, ST_SLEEP: begin
                if (cmd_wr_i) begin
                    wd_clr_o = 1'b1;
                    if (cmd_mode_i == CMD_NORMAL)       nxt_st = ST_NORMAL;
                    else if (cmd_mode_i == CMD_STANDBY) nxt_st = ST_STANDBY;
                    else if (cmd_mode_i == CMD_SLEEP)   nxt_st = ST_SLEEP;
                end else if (wd_expire_i) begin
                    wd_clr_o = 1'b1;
                    fail     = 1'b1;
                    fail_src = RSRC_TIMEOUT;
                end
            end
            ST_FLASH: begin
                if (cmd_wr_i) begin
                    wd_clr_o = 1'b1;
                    if (cmd_mode_i == CMD_NORMAL) nxt_st = ST_NORMAL;
                end else if (wd_expire_i) begin
                    wd_clr_o = 1'b1;
                    fail     = 1'b1;
                    fail_src = RSRC_TIMEOUT;
                end
            end
            ST_FAILSAFE: begin
                wd_clr_o = 1'b1;
            end
            default: begin
                nxt_st   = ST_FAILSAFE;
                wd_clr_o = 1'b1;
            end
        endcase
        if (fail && !dev_i) begin
            nxt_st    = ST_STARTUP;
            nxt_req   = 1'b1;
            nxt_src   = fail_src;
            nxt_step  = 2'd0;
            nxt_armed = 1'b0;
            nxt_retry = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_STARTUP;
            retry <= 1'b0;
            step  <= 2'd0;
            armed <= 1'b0;
        end else begin
            st    <= nxt_st;
            retry <= nxt_retry;
            step  <= nxt_step;
            armed <= nxt_armed;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req_o <= 1'b0;
            rst_src_o <= RSRC_POWERON;
        end else begin
            rst_req_o <= nxt_req;
            rst_src_o <= nxt_src;
        end
    end

    assign mode_o = st;

    // R11: reset request is a single-cycle pulse
    a_r11_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    // R11: a reset request coincides with the Start-up mode
    a_r11_req_in_startup: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> st == ST_STARTUP);

    // R7: Fail-safe holds and never requests a reset
    a_r7_failsafe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_FAILSAFE |=> st == ST_FAILSAFE && !rst_req_o);

    // R6: Fail-safe is reached only from Start-up after a retry
    a_r6_failsafe_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FAILSAFE && $past(st) != ST_FAILSAFE) |-> ($past(st) == ST_STARTUP && $past(retry)));

    // R9: Flash is entered only from Start-up
    a_r9_flash_from_startup: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FLASH && $past(st) != ST_FLASH) |-> $past(st) == ST_STARTUP);

    // R10: with the bypass set a watchdog expiry requests no reset
    a_r10_dev_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dev_i) && $past(wd_expire_i) && !$past(cmd_wr_i)) |-> !rst_req_o);

    // R2: an early write in Normal never reaches a low-power mode
    a_r2_early_no_mode: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_NORMAL && $past(cmd_wr_i) && $past(wd_early_i))
            |-> (st != ST_STANDBY && st != ST_SLEEP));

endmodule

// File: rtl/sbc_mode_supervisor.sv
module sbc_mode_supervisor
    import sbcsup_pkg::*;
#(
    parameter int BASE_DIV      = 4,
    parameter int STARTUP_TICKS = 32,
    parameter int PERIOD_W      = 6,
    localparam int LIM_MAX      = (STARTUP_TICKS > (1 << PERIOD_W)) ? STARTUP_TICKS : (1 << PERIOD_W),
    localparam int CW           = $clog2(LIM_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_wr,
    input  logic [2:0]          cmd_mode,
    input  logic [PERIOD_W-1:0] cmd_period,
    input  logic                cfg_wr,
    input  logic [1:0]          cfg_prescale,
    input  logic                cfg_devmode,
    output logic [2:0]          mode,
    output logic                reset_req,
    output logic [3:0]          reset_src
);

    logic [PERIOD_W-1:0] period_q;
    logic [1:0]          pre_q;
    logic                dev_q;
    sbc_mode_e           cur_mode;
    logic                wd_clr, tick, wd_expire, wd_early;
    logic [CW-1:0]       limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
            pre_q    <= 2'd0;
            dev_q    <= 1'b0;
        end else begin
            if (cmd_wr && cur_mode != ST_FAILSAFE) period_q <= cmd_period;
            if (cfg_wr) begin
                pre_q <= cfg_prescale;
                dev_q <= cfg_devmode;
            end
        end
    end

    assign limit = (cur_mode == ST_STARTUP) ? CW'(STARTUP_TICKS)
                                            : CW'(period_q) + CW'(1);

    sbcsup_tick_gen #(.BASE_DIV(BASE_DIV)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (wd_clr),
        .pre_i  (pre_q),
        .tick_o (tick)
    );

    sbcsup_wdog #(.CW(CW)) i_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (wd_clr),
        .tick_i   (tick),
        .limit_i  (limit),
        .expire_o (wd_expire),
        .early_o  (wd_early)
    );

    sbcsup_mode_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr_i    (cmd_wr),
        .cmd_mode_i  (cmd_mode),
        .dev_i       (dev_q),
        .wd_expire_i (wd_expire),
        .wd_early_i  (wd_early),
        .mode_o      (cur_mode),
        .rst_req_o   (reset_req),
        .rst_src_o   (reset_src),
        .wd_clr_o    (wd_clr)
    );

    assign mode = cur_mode;

endmodule

// File: tb/test_sbc_mode_supervisor.sv
module test_sbc_mode_supervisor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [2:0] cmd_mode = 3'd0;
    logic [5:0] cmd_period = 6'd0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_prescale = 2'd0;
    logic       cfg_devmode = 1'b0;
    logic [2:0] mode;
    logic       reset_req;
    logic [3:0] reset_src;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    sbc_mode_supervisor #(.BASE_DIV(4), .STARTUP_TICKS(32), .PERIOD_W(6)) i_sbc_mode_supervisor (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_mode(cmd_mode),
        .cmd_period(cmd_period), .cfg_wr(cfg_wr), .cfg_prescale(cfg_prescale),
        .cfg_devmode(cfg_devmode), .mode(mode), .reset_req(reset_req), .reset_src(reset_src)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [2:0] m, input logic [5:0] p);
        cmd_mode = m; cmd_period = p; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic do_cfg(input logic [1:0] pre, input logic dev);
        cfg_prescale = pre; cfg_devmode = dev; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic por();
        rst_n = 1'b0; cmd_wr = 1'b0; cfg_wr = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        wait_n(2);
        check("R1 mode in reset", 8'(mode), 8'd0);
        check("R1 src in reset", 8'(reset_src), 8'h1);
        por();
        check("R1 mode after reset", 8'(mode), 8'd0);
        check("R1 req after reset", 8'(reset_req), 8'd0);
    endtask

    task automatic t_modes_and_timeout();
        por();
        do_write(3'b101, 6'd7);
        check("R12 startup to normal", 8'(mode), 8'd1);
        wait_n(19); do_write(3'b010, 6'd7);
        check("R3 R12 accepted window write to sleep", 8'(mode), 8'd3);
        do_write(3'b110, 6'd7);
        check("R12 sleep to standby", 8'(mode), 8'd2);
        wait_n(31);
        check("R4 R5 standby before expiry", 8'(mode), 8'd2);
        wait_n(1);
        check("R4 timeout to startup", 8'(mode), 8'd0);
        check("R4 timeout source", 8'(reset_src), 8'h5);
        check("R11 req pulse high", 8'(reset_req), 8'd1);
        wait_n(1);
        check("R11 req pulse ends", 8'(reset_req), 8'd0);
        check("R11 source holds", 8'(reset_src), 8'h5);
    endtask

    task automatic t_window_early();
        por();
        do_write(3'b101, 6'd7);
        wait_n(9); do_write(3'b110, 6'd7);
        check("R2 R3 early write no standby", 8'(mode), 8'd0);
        check("R3 early source", 8'(reset_src), 8'h3);
        check("R11 early req", 8'(reset_req), 8'd1);
    endtask

    task automatic t_window_late();
        por();
        do_write(3'b101, 6'd7);
        wait_n(31);
        check("R3 normal before deadline", 8'(mode), 8'd1);
        wait_n(1);
        check("R3 late to startup", 8'(mode), 8'd0);
        check("R3 late source", 8'(reset_src), 8'h4);
    endtask

    task automatic t_startup_retry();
        logic [7:0] seen;
        por();
        wait_n(127);
        check("R5 R6 startup before first miss", 8'(reset_req), 8'd0);
        wait_n(1);
        check("R6 first miss req", 8'(reset_req), 8'd1);
        check("R6 first miss source", 8'(reset_src), 8'h2);
        check("R6 first miss stays startup", 8'(mode), 8'd0);
        wait_n(127);
        check("R6 still startup", 8'(mode), 8'd0);
        wait_n(1);
        check("R6 second miss failsafe", 8'(mode), 8'd5);
        check("R6 no pulse into failsafe", 8'(reset_req), 8'd0);
        do_write(3'b101, 6'd7);
        check("R7 write ignored in failsafe", 8'(mode), 8'd5);
        seen = 8'd0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (reset_req) seen = 8'd1;
        end
        check("R7 no reset pulse in failsafe", seen, 8'd0);
        check("R7 failsafe holds", 8'(mode), 8'd5);
        por();
        check("R7 R1 power-on leaves failsafe", 8'(mode), 8'd0);
        check("R1 source after power-on", 8'(reset_src), 8'h1);
    endtask

    task automatic t_prescale();
        por();
        do_cfg(2'd1, 1'b0);
        do_write(3'b101, 6'd3);
        wait_n(63);
        check("R5 prescaled normal before deadline", 8'(mode), 8'd1);
        wait_n(1);
        check("R5 prescaled deadline", 8'(mode), 8'd0);
        check("R5 prescaled late source", 8'(reset_src), 8'h4);
    endtask

    task automatic t_devmode();
        logic [7:0] seen;
        por();
        do_cfg(2'd0, 1'b1);
        do_write(3'b101, 6'd7);
        wait_n(9); do_write(3'b110, 6'd7);
        check("R10 R2 early write with bypass keeps normal", 8'(mode), 8'd1);
        check("R10 early write with bypass no req", 8'(reset_req), 8'd0);
        seen = 8'd0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (reset_req) seen = 8'd1;
        end
        check("R10 expiry with bypass no req", seen, 8'd0);
        check("R10 expiry with bypass keeps normal", 8'(mode), 8'd1);
        check("R10 source unchanged", 8'(reset_src), 8'h1);
    endtask

    task automatic t_flash_entry();
        por();
        do_write(3'b101, 6'd7);
        wait_n(19); do_write(3'b101, 6'd7);
        wait_n(19); do_write(3'b001, 6'd7);
        wait_n(19); do_write(3'b101, 6'd7);
        check("R8 mid sequence stays normal", 8'(mode), 8'd1);
        check("R8 mid sequence no req", 8'(reset_req), 8'd0);
        wait_n(19); do_write(3'b001, 6'd7);
        check("R8 sequence ends in startup", 8'(mode), 8'd0);
        check("R8 flash entry source", 8'(reset_src), 8'h6);
        check("R8 flash entry req", 8'(reset_req), 8'd1);
        do_write(3'b011, 6'd7);
        check("R9 ack enters flash", 8'(mode), 8'd4);
        do_write(3'b101, 6'd7);
        check("R12 flash to normal", 8'(mode), 8'd1);
        wait_n(32);
        check("R3 late miss back to startup", 8'(mode), 8'd0);
        do_write(3'b011, 6'd7);
        check("R9 second ack ignored", 8'(mode), 8'd0);
    endtask

    task automatic t_ack_unarmed();
        por();
        do_write(3'b011, 6'd7);
        check("R9 ack without sequence ignored", 8'(mode), 8'd0);
        do_write(3'b110, 6'd7);
        check("R12 standby code ignored in startup", 8'(mode), 8'd0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_modes_and_timeout();
        t_window_early();
        t_window_late();
        t_startup_retry();
        t_prescale();
        t_devmode();
        t_flash_entry();
        t_ack_unarmed();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

endmodule